// File: doc/BRIEF.md
# Set-Associative Cache Tag Classifier

This block keeps the tag, valid and dirty directory of a set-associative cache that holds no data. Each cycle it may receive one access, made of a physical address and a write flag. Within the same cycle it reports what that access does to the cache. The possible outcomes are a hit, a miss that fills an empty way, an eviction of a clean line, or an eviction of a dirty line that would need a writeback. The new line state is committed on the next rising clock edge.

Replacement uses a tree pseudo-LRU. Each set has its own tree of WAYS-1 bits. At each node, a bit of 0 points the victim search to the lower half of the ways and a bit of 1 points it to the upper half. A touch sets every node on the touched way's path so that it points away from that way. Three whole-cache commands are available:
- Flush cleans every line.
- Invalidate empties every line.
- Test clear empties every line and also zeroes all replacement trees.

The block is meant for checking a cache controller against a reference, or for collecting hit and miss statistics.

Top module: `cache_tag_classifier`

## Requirements
- R1: The tag is taken from the top TAG_W address bits. The set index comes from the log2(SETS) bits below the tag. The remaining low bits are the offset and are ignored, so addresses that differ only in the offset refer to the same line.
- R2: A valid line in the indexed set with a matching tag is a hit. The outcome code is 2'b00, res_way is the matching way, and the line's dirty bit becomes its old value OR acc_write.
- R3: On a miss in a set that has an invalid way, the lowest-numbered invalid way is filled. The tag is stored, valid is set, dirty is set equal to acc_write, and the outcome code is 2'b01.
- R4: On a miss in a set where every way is valid, the pseudo-LRU victim is overwritten and its dirty bit is set to acc_write. The outcome code is 2'b11 if the victim was dirty and 2'b10 if it was clean.
- R5: Every accepted access (hit, fill or eviction) updates the indexed set's tree so that every node on the touched way's path points away from that way.
- R6: flush_all clears every dirty bit. Valid bits, tags and trees are left unchanged.
- R7: inval_all clears every valid bit. Dirty bits and trees are left unchanged.
- R8: clear_all clears every valid bit and resets every tree bit to 0.
- R9: When any command is asserted, a concurrent access is ignored. res_valid stays 0 and no tag, valid, dirty or tree bit changes because of that access.
- R10: After reset, all lines are invalid, all tree bits are 0, and res_valid is 0 whenever acc_valid is 0.
- R11: res_valid is 1 exactly in the cycles where acc_valid is 1 and no command is asserted. In those cycles res_way identifies the way that was hit, filled or evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | The access is a write |
| flush_all | input | 1 | Clear all dirty bits |
| inval_all | input | 1 | Clear all valid bits |
| clear_all | input | 1 | Test clear: invalidate all lines and zero all trees |
| res_valid | output | 1 | Outcome is valid this cycle |
| res_code | output | 2 | 00 hit, 01 fill, 10 clean evict, 11 dirty evict |
| res_way | output | WAY_W | Way that was touched |

## Verification
The hardest outcome to reach from the ports is a dirty eviction whose victim was chosen by a specific tree state. To get there, a set must be filled completely, one of its lines must be written, and the access order must then steer the tree towards that line. A fixed sequence in one set covers this: it passes through every outcome code and an eviction of a written line. A second fixed sequence shows that a flush turns what would have been a dirty eviction into a clean one, and that commands override a concurrent access. A long random phase follows, using a handful of tags and occasional commands, and is compared cycle by cycle against a behavioural model.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [1:0] {
        OC_HIT   = 2'b00,
        OC_FILL  = 2'b01,
        OC_CLEAN = 2'b10,
        OC_DIRTY = 2'b11
    } outcome_e;

endpackage

// File: rtl/cdir_plru.sv
// Tree pseudo-LRU for one set: victim choice and update after a touch.
module cdir_plru #(
    parameter int WAYS = 4,
    localparam int LOG_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int PL_W  = (WAYS > 1) ? WAYS - 1 : 1
) (
    input  logic [PL_W-1:0]  tree_i,
    input  logic [LOG_W-1:0] touch_way,
    output logic [PL_W-1:0]  tree_o,
    output logic [LOG_W-1:0] victim_o
);

    generate
        if (WAYS == 1) begin : g_single
            logic unused_bits;
            assign unused_bits = ^{tree_i, touch_way};
            assign tree_o   = '0;
            assign victim_o = '0;
        end else begin : g_tree
            // Touch: every node on the path points to the other half.
            always_comb begin
                int node_d;
                tree_o = tree_i;
                for (int lvl = 0; lvl < LOG_W; lvl++) begin
                    node_d = (1 << lvl) - 1 + (int'(touch_way) >> (LOG_W - lvl));
                    tree_o[node_d] = ~touch_way[LOG_W-1-lvl];
                end
            end

            // Victim: follow node bits from the root; each bit is one way bit.
            always_comb begin
                int node_q;
                logic bit_q;
                node_q   = 0;
                victim_o = '0;
                for (int lvl = 0; lvl < LOG_W; lvl++) begin
                    bit_q = tree_i[node_q];
                    victim_o[LOG_W-1-lvl] = bit_q;
                    node_q = 2 * node_q + 1 + int'(bit_q);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cdir_lookup.sv
// Tag compare across one set, plus a search for the lowest invalid way.
module cdir_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int LOG_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [LOG_W-1:0]           hit_way_o,
    output logic                       free_o,
    output logic [LOG_W-1:0]           free_way_o
);

    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
        end
    endgenerate

    always_comb begin
        hit_o      = 1'b0;
        hit_way_o  = '0;
        free_o     = 1'b0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_o     = 1'b1;
                hit_way_o = LOG_W'(w);
            end
            if (!valid_i[w]) begin
                free_o     = 1'b1;
                free_way_o = LOG_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache_tag_classifier.sv
module cache_tag_classifier #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              flush_all,
    input  logic              inval_all,
    input  logic              clear_all,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic [WAY_W-1:0]  res_way
);
    import cdir_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int OFF_W = ADDR_W - TAG_W - SET_W;
    localparam int PL_W  = (WAYS > 1) ? WAYS - 1 : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            dirty;
        logic [SETS-1:0][PL_W-1:0]            plru;
    } dir_state_t;

    dir_state_t s_d, s_q;

    logic [TAG_W-1:0] tag_in;
    logic [SET_W-1:0] set_idx;
    logic             any_cmd;
    logic             hit, free;
    logic [WAY_W-1:0] hit_way, free_way, victim, way_sel;
    logic [PL_W-1:0]  tree_upd;

    assign tag_in  = acc_addr[ADDR_W-1 -: TAG_W];
    assign set_idx = acc_addr[OFF_W +: SET_W];
    assign any_cmd = flush_all | inval_all | clear_all;

    generate
        if (OFF_W > 0) begin : g_off
            logic unused_offset;
            assign unused_offset = ^acc_addr[OFF_W-1:0];
        end
    endgenerate

    cdir_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .tags_i    (s_q.tag[set_idx]),
        .valid_i   (s_q.valid[set_idx]),
        .tag_i     (tag_in),
        .hit_o     (hit),
        .hit_way_o (hit_way),
        .free_o    (free),
        .free_way_o(free_way)
    );

    assign way_sel = hit ? hit_way : (free ? free_way : victim);

    cdir_plru #(.WAYS(WAYS)) u_plru (
        .tree_i   (s_q.plru[set_idx]),
        .touch_way(way_sel),
        .tree_o   (tree_upd),
        .victim_o (victim)
    );

    always_comb begin
        s_d       = s_q;
        res_valid = 1'b0;
        res_code  = OC_HIT;
        res_way   = way_sel;

        if (flush_all)             s_d.dirty = '0;
        if (inval_all | clear_all) s_d.valid = '0;
        if (clear_all)             s_d.plru  = '0;

        if (acc_valid && !any_cmd) begin
            res_valid = 1'b1;
            if (hit) begin
                res_code = OC_HIT;
                s_d.dirty[set_idx][way_sel] = s_q.dirty[set_idx][way_sel] | acc_write;
            end else begin
                if (free)
                    res_code = OC_FILL;
                else if (s_q.dirty[set_idx][way_sel])
                    res_code = OC_DIRTY;
                else
                    res_code = OC_CLEAN;
                s_d.tag[set_idx][way_sel]   = tag_in;
                s_d.dirty[set_idx][way_sel] = acc_write;
            end
            s_d.valid[set_idx][way_sel] = 1'b1;
            s_d.plru[set_idx]           = tree_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: a write access leaves its line dirty
    a_r2_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && acc_write) |=> s_q.dirty[$past(set_idx)][$past(res_way)]);

    // R3: a fill lands in a way that was empty
    a_r3_fill_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'b01) |-> !s_q.valid[set_idx][res_way]);

    // R4: evictions happen only in a full set
    a_r4_evict_needs_full_set: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code[1]) |-> (&s_q.valid[set_idx]));

    // R6: flush leaves no dirty line
    a_r6_flush_cleans: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (s_q.dirty == '0));

    // R7: invalidate empties lines but keeps trees
    a_r7_inval_keeps_tree: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all && !clear_all) |=> (s_q.valid == '0 && $stable(s_q.plru)));

    // R8: test clear empties lines and zeroes trees
    a_r8_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (s_q.valid == '0 && s_q.plru == '0));

    // R9: tags never change when a command coincides with an access
    a_r9_cmd_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmd && acc_valid) |=> $stable(s_q.tag));

endmodule

// File: tb/cache_tag_classifier_tb.sv
module cache_tag_classifier_tb;

    localparam int SETS = 16, WAYS = 4, ADDR_W = 16, TAG_W = 8;
    localparam int OFF_B = ADDR_W - TAG_W - 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic flush_all = 1'b0, inval_all = 1'b0, clear_all = 1'b0;
    logic res_valid;
    logic [1:0] res_code;
    logic [1:0] res_way;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // reference state
    int m_tag [SETS][WAYS];
    bit m_val [SETS][WAYS];
    bit m_dty [SETS][WAYS];
    bit m_tree[SETS][WAYS-1];

    always #10 clk = ~clk;

    cache_tag_classifier #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .flush_all(flush_all), .inval_all(inval_all),
        .clear_all(clear_all), .res_valid(res_valid), .res_code(res_code), .res_way(res_way)
    );

    task automatic touch(input int s, input int w);
        int idx, bottom;
        bottom = (WAYS - 1) / 2;
        idx = w / 2 + bottom;
        m_tree[s][idx] = (w % 2 == 0);
        while (idx > 0) begin
            m_tree[s][(idx - 1) / 2] = (idx % 2 == 1);
            idx = (idx - 1) / 2;
        end
    endtask

    function automatic int pick_victim(input int s);
        int idx, bottom;
        bottom = (WAYS - 1) / 2;
        idx = 0;
        while (idx < bottom) idx = m_tree[s][idx] ? 2 * idx + 2 : 2 * idx + 1;
        return (idx - bottom) * 2 + int'(m_tree[s][idx]);
    endfunction

    task automatic model_clear_all();
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0;
            end
            for (int n = 0; n < WAYS - 1; n++) m_tree[s][n] = 0;
        end
    endtask

    // Computes expected outputs for the cycle and commits the model state.
    task automatic model_step(input bit v, input int addr, input bit wr, input bit f,
                              input bit inv, input bit clr,
                              output bit e_valid, output int e_code, output int e_way);
        int tg, st, way;
        bit found;
        e_valid = 0; e_code = 0; e_way = -1;
        tg = addr >> (ADDR_W - TAG_W);
        st = (addr >> OFF_B) % SETS;
        if (f) for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_dty[s][w] = 0;
        if (inv || clr) for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
        if (clr) for (int s = 0; s < SETS; s++) for (int n = 0; n < WAYS - 1; n++) m_tree[s][n] = 0;
        if (v && !f && !inv && !clr) begin
            e_valid = 1;
            found = 0;
            for (int w = 0; w < WAYS; w++)
                if (!found && m_val[st][w] && m_tag[st][w] == tg) begin found = 1; way = w; end
            if (found) begin
                e_code = 0;
                m_dty[st][way] = m_dty[st][way] | wr;
            end else begin
                for (int w = 0; w < WAYS; w++)
                    if (!found && !m_val[st][w]) begin found = 1; way = w; end
                if (found) e_code = 1;
                else begin
                    way = pick_victim(st);
                    e_code = m_dty[st][way] ? 3 : 2;
                end
                m_tag[st][way] = tg; m_val[st][way] = 1; m_dty[st][way] = wr;
            end
            touch(st, way);
            e_way = way;
        end
    endtask

    // One cycle: drive, compare against the model, optionally against a fixed expectation.
    task automatic step(input bit v, input int addr, input bit wr, input bit f, input bit inv,
                        input bit clr, input int x_code, input int x_way, input string req);
        bit e_valid;
        int e_code, e_way;
        @(negedge clk);
        acc_valid = v; acc_addr = ADDR_W'(addr); acc_write = wr;
        flush_all = f; inval_all = inv; clear_all = clr;
        #5;
        model_step(v, addr, wr, f, inv, clr, e_valid, e_code, e_way);
        compared++;
        if (res_valid !== e_valid || (e_valid && (int'(res_code) != e_code || int'(res_way) != e_way))) begin
            mismatched++;
            $display("FAIL %s addr=%h: got valid=%0b code=%0d way=%0d, expected valid=%0b code=%0d way=%0d",
                     req, addr, res_valid, res_code, res_way, e_valid, e_code, e_way);
        end
        if (x_code >= -1) begin
            compared++;
            if ((x_code == -1 && res_valid !== 1'b0) ||
                (x_code >= 0 && (res_valid !== 1'b1 || int'(res_code) != x_code || int'(res_way) != x_way))) begin
                mismatched++;
                $display("FAIL %s addr=%h: got valid=%0b code=%0d way=%0d, expected code=%0d way=%0d",
                         req, addr, res_valid, res_code, res_way, x_code, x_way);
            end
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_clear_all();
        repeat (3) @(negedge clk);
        #5;
        compared++;
        if (res_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R10 in reset: got res_valid=%0b expected 0", res_valid);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, -1, 0, "R10 idle");

        // Set 0xC sequence
        step(1, 'hABCD, 0, 0, 0, 0, 1, 0, "R1 R3 fill way0");
        step(1, 'hABC3, 0, 0, 0, 0, 0, 0, "R1 offset ignored hit");
        step(1, 'hABCD, 1, 0, 0, 0, 0, 0, "R2 write hit");
        step(1, 'hACCD, 0, 0, 0, 0, 1, 1, "R3 fill way1");
        step(1, 'hADCD, 0, 0, 0, 0, 1, 2, "R3 fill way2");
        step(1, 'hAECD, 0, 0, 0, 0, 1, 3, "R3 fill way3");
        step(1, 'hABCD, 0, 0, 0, 0, 0, 0, "R5 hit way0");
        step(1, 'hADCD, 0, 0, 0, 0, 0, 2, "R5 hit way2");
        step(1, 'hAFCD, 0, 0, 0, 0, 2, 1, "R4 R5 clean evict way1");
        step(1, 'hACCD, 0, 0, 0, 0, 2, 3, "R4 R5 clean evict way3");
        step(1, 'hEAC2, 0, 0, 0, 0, 3, 0, "R4 dirty evict way0");

        // Flush turns a dirty victim clean, tags survive
        step(0, 0, 0, 0, 0, 1, -1, 0, "R8 clear");
        step(1, 'h1010, 0, 0, 0, 0, 1, 0, "R8 empty after clear");
        step(1, 'h1010, 1, 0, 0, 0, 0, 0, "R2 write hit set1");
        step(1, 'h1110, 0, 0, 0, 0, 1, 1, "R3 fill set1");
        step(1, 'h1210, 0, 0, 0, 0, 1, 2, "R3 fill set1");
        step(1, 'h1310, 0, 0, 0, 0, 1, 3, "R3 fill set1");
        step(0, 0, 0, 1, 0, 0, -1, 0, "R6 flush");
        step(1, 'h1410, 0, 0, 0, 0, 2, 0, "R6 flushed victim clean");
        step(1, 'h1110, 0, 0, 0, 0, 0, 1, "R6 tags kept");

        // Invalidate
        step(0, 0, 0, 0, 1, 0, -1, 0, "R7 invalidate");
        step(1, 'h1110, 0, 0, 0, 0, 1, 0, "R7 line gone");

        // Command with concurrent access
        step(1, 'h3330, 1, 1, 0, 0, -1, 0, "R9 flush blocks access");
        step(1, 'h3330, 0, 0, 1, 0, -1, 0, "R9 inval blocks access");
        step(1, 'h3330, 0, 0, 0, 0, 1, 0, "R9 access not installed");
        step(1, 'h3330, 0, 0, 0, 0, 0, 0, "R11 hit way0");

        // Random phase with few tags and sets
        for (int k = 0; k < 4000; k++) begin
            int r, a;
            r = int'($urandom_range(0, 99));
            a = (int'($urandom_range(0, 5)) << 8) | (int'($urandom_range(0, 1)) << 4) | int'($urandom_range(0, 15));
            if (r < 2)      step(int'($urandom_range(0, 1)), a, 0, 1, 0, 0, -2, 0, "R6 random");
            else if (r < 3) step(int'($urandom_range(0, 1)), a, 0, 0, 1, 0, -2, 0, "R7 random");
            else if (r < 4) step(int'($urandom_range(0, 1)), a, 0, 0, 0, 1, -2, 0, "R8 random");
            else if (r < 10) step(0, a, 0, 0, 0, 0, -2, 0, "R11 random idle");
            else step(1, a, bit'($urandom_range(0, 1)), 0, 0, 0, -2, 0, "R2 R3 R4 R5 random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule